// File: doc/BRIEF.md
# Stepped Soft Mute Attenuator

This block scales a stereo stream of signed samples by a shared gain that fades smoothly to silence when a mute control goes high and fades back to full level when the control goes low. The gain moves through a fixed number of discrete attenuation steps. The block holds each step for a fixed number of input samples, so a complete fade lasts a known number of sample periods whatever the clock rate is. A mute change in the middle of a fade turns the ramp around from the step it has reached. A reset always leaves the path at full level.

Each accepted sample pair produces one output pair, registered one clock later. A status flag reports when the attenuation has reached its last step and both outputs are held at exact zero. The mute control is meant to stay high for at least one step's worth of samples. Shorter pulses are outside the supported input range.

Top module: `soft_mute_ramp`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `out_valid` is 0, both outputs are 0, `muted` is 0 and the attenuation step is 0 (full level).
- R2: `out_valid` is 1 in exactly the cycle after each cycle with `smp_valid` high. In the other cycles it is 0 and both outputs keep their values.
- R3: At step 0 each output equals its input sample bit for bit.
- R4: At step k, where 0 < k < 128, the gain is the 16-bit fraction (128 - k) * 512 / 65536. Each output is (x * (128 - k) * 512 + 32768) shifted right arithmetically by 16 bits, where x is the signed 16-bit input.
- R5: While `mute` is 1 and the step is below 128, the step rises by one on every 8th strobe. A fade from full level to silence takes exactly 1024 strobes.
- R6: While `mute` is 0 and the step is above 0, the step falls by one on every 8th strobe. A fade back to full level takes exactly 1024 strobes.
- R7: When `mute` changes in the middle of a fade, the step is kept and the count of strobes toward the next step is kept. The ramp then continues in the new direction.
- R8: At step 128 both outputs are exactly 0 for any input. `muted` is 1 only while the step is 128.
- R9: Both channels always use the same step. Each channel's output depends only on its own input sample.
- R10: Changes on `mute` in cycles without a strobe do not move the step. `muted` and later outputs are unaffected until strobes arrive.
- R11: A reset asserted in the middle of a fade returns the block to step 0, so the next sample passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mute | input | 1 | 1 ramps toward silence, 0 ramps toward full level |
| smp_valid | input | 1 | Strobe: one stereo sample pair is present |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| out_valid | output | 1 | Scaled pair is valid |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| muted | output | 1 | Attenuation has reached its last step |

## Verification
A scaled pair appears one clock after its strobe edge. It uses the step that was in force before that edge. A step change made on the same edge first affects the flag and the following sample. The bench drives inputs on falling edges and samples each result on the falling edge after the strobe. It keeps a strobe-by-strobe model of the step and dwell count built from the requirements, so every expected value is tied to the step in force when that sample was taken. Hand-computed values fix the boundary at strobe 1023 versus 1024, the step reached after a mid-fade reversal, and full-scale negative input at the silent step.

// File: rtl/smr_pkg.sv
package smr_pkg;

   // Direction the attenuation step will move on the next dwell expiry
   typedef enum logic [1:0] {
      MV_HOLD    = 2'd0,
      MV_ATTEN   = 2'd1,
      MV_RESTORE = 2'd2
   } step_move_e;

endpackage

// File: rtl/smr_step_ctrl.sv
module smr_step_ctrl
   import smr_pkg::*;
#(
   parameter int STEPS = 128,
   parameter int DWELL = 8,
   parameter int IDX_W = $clog2(STEPS + 1),
   parameter int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mute,
   input  logic             strobe,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(STEPS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL - 1);

   logic [CNT_W-1:0] dwell_q;
   step_move_e       move;

   always_comb begin
      move = MV_HOLD;
      if (mute && (idx != IDX_END))
         move = MV_ATTEN;
      else if (!mute && (idx != '0))
         move = MV_RESTORE;
   end

   // The dwell count is kept across a reversal; it returns to zero only on a step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx     <= '0;
         dwell_q <= '0;
      end else if (strobe && (move != MV_HOLD)) begin
         if (dwell_q == CNT_LAST) begin
            dwell_q <= '0;
            idx     <= (move == MV_ATTEN) ? idx + 1'b1 : idx - 1'b1;
         end else begin
            dwell_q <= dwell_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/smr_gain_curve.sv
module smr_gain_curve #(
   parameter int STEPS  = 128,
   parameter int GAIN_W = 16,
   parameter int IDX_W  = $clog2(STEPS + 1)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [GAIN_W-1:0] gain_frac,
   output logic              unity,
   output logic              silent
);

   localparam int              SHIFT   = GAIN_W - $clog2(STEPS);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(STEPS);

   logic [IDX_W-1:0] remain;

   always_comb begin
      remain    = IDX_END - idx;
      gain_frac = GAIN_W'(remain) << SHIFT;
      unity     = (idx == '0);
      silent    = (idx == IDX_END);
   end

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
   parameter int SAMPLE_W = 16,
   parameter int GAIN_W   = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic        [GAIN_W-1:0]   gain_frac,
   input  logic                       unity,
   input  logic                       silent,
   output logic signed [SAMPLE_W-1:0] result
);

   localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

   logic signed [PROD_W-1:0] samp_x;
   logic signed [PROD_W-1:0] gain_x;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] biased;
   logic signed [SAMPLE_W-1:0] scaled;
   logic unused_bits;

   assign samp_x = PROD_W'(sample);
   assign gain_x = $signed(PROD_W'({1'b0, gain_frac}));
   assign prod   = samp_x * gain_x;

   generate
      if (ROUND_EN) begin : g_round
         assign biased = prod + (PROD_W'(1) <<< (GAIN_W - 1));
      end else begin : g_trunc
         assign biased = prod;
      end
   endgenerate

   assign scaled      = biased[GAIN_W +: SAMPLE_W];
   assign unused_bits = ^{biased[GAIN_W-1:0], biased[PROD_W-1]};

   always_comb begin
      if (silent)
         result = '0;
      else if (unity)
         result = sample;
      else
         result = scaled;
   end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
   parameter int SAMPLE_W = 16,
   parameter int GAIN_W   = 16,
   parameter int STEPS    = 128,
   parameter int DWELL    = 8,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mute,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_left,
   input  logic signed [SAMPLE_W-1:0] smp_right,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_left,
   output logic signed [SAMPLE_W-1:0] out_right,
   output logic                       muted
);

   localparam int IDX_W = $clog2(STEPS + 1);
   localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
   localparam int N_CH  = 2;

   generate
      if ((STEPS < 2) || ((STEPS & (STEPS - 1)) != 0)) begin : g_bad_steps
         $error("STEPS must be a power of two of at least 2");
      end
      if (GAIN_W <= $clog2(STEPS)) begin : g_bad_gain
         $error("GAIN_W must exceed log2(STEPS)");
      end
      if (DWELL < 1) begin : g_bad_dwell
         $error("DWELL must be at least 1");
      end
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("SAMPLE_W must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0]          step_idx;
   logic [GAIN_W-1:0]         gain_frac;
   logic                      gain_unity;
   logic                      gain_silent;
   logic signed [SAMPLE_W-1:0] ch_in  [N_CH];
   logic signed [SAMPLE_W-1:0] ch_res [N_CH];

   smr_step_ctrl #(
      .STEPS (STEPS),
      .DWELL (DWELL),
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
   ) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .mute   (mute),
      .strobe (smp_valid),
      .idx    (step_idx)
   );

   smr_gain_curve #(
      .STEPS  (STEPS),
      .GAIN_W (GAIN_W),
      .IDX_W  (IDX_W)
   ) u_curve (
      .idx       (step_idx),
      .gain_frac (gain_frac),
      .unity     (gain_unity),
      .silent    (gain_silent)
   );

   assign ch_in[0] = smp_left;
   assign ch_in[1] = smp_right;

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         smr_scaler #(
            .SAMPLE_W (SAMPLE_W),
            .GAIN_W   (GAIN_W),
            .ROUND_EN (ROUND_EN)
         ) u_scale (
            .sample    (ch_in[c]),
            .gain_frac (gain_frac),
            .unity     (gain_unity),
            .silent    (gain_silent),
            .result    (ch_res[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_left  <= '0;
         out_right <= '0;
      end else begin
         out_valid <= smp_valid;
         if (smp_valid) begin
            out_left  <= ch_res[0];
            out_right <= ch_res[1];
         end
      end
   end

   assign muted = gain_silent;

endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
   parameter int SAMPLE_W = 16,
   parameter int STEPS    = 128,
   parameter int IDX_W    = $clog2(STEPS + 1)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       mute,
   input logic                       smp_valid,
   input logic signed [SAMPLE_W-1:0] smp_left,
   input logic signed [SAMPLE_W-1:0] smp_right,
   input logic                       out_valid,
   input logic signed [SAMPLE_W-1:0] out_left,
   input logic signed [SAMPLE_W-1:0] out_right,
   input logic [IDX_W-1:0]           step_idx
);

   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(STEPS);

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> out_valid);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

   assert_unity_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && (step_idx == '0)) |=>
         ((out_left == $past(smp_left)) && (out_right == $past(smp_right))));

   assert_silent_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && (step_idx == IDX_END)) |=> ((out_left == '0) && (out_right == '0)));

   assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step_idx <= IDX_END);

   assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_idx > $past(step_idx)) |-> ((step_idx == $past(step_idx) + 1'b1) && $past(mute)));

   assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_idx < $past(step_idx)) |-> ((step_idx == $past(step_idx) - 1'b1) && !$past(mute)));

   assert_no_strobe_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(step_idx) |-> $past(smp_valid));

endmodule

bind soft_mute_ramp smr_checker #(
   .SAMPLE_W (SAMPLE_W),
   .STEPS    (STEPS),
   .IDX_W    (IDX_W)
) u_smr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mute      (mute),
   .smp_valid (smp_valid),
   .smp_left  (smp_left),
   .smp_right (smp_right),
   .out_valid (out_valid),
   .out_left  (out_left),
   .out_right (out_right),
   .step_idx  (step_idx)
);

// File: tb/soft_mute_ramp_bench.sv
module soft_mute_ramp_bench;

   logic clk = 1'b0;
   logic rst_n;
   logic mute;
   logic smp_valid;
   logic signed [15:0] smp_left;
   logic signed [15:0] smp_right;
   logic out_valid;
   logic signed [15:0] out_left;
   logic signed [15:0] out_right;
   logic muted;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 1'b0;

   // Bench model of the attenuation step, built from R5..R7
   int m_idx = 0;
   int m_cnt = 0;

   always #10 clk = ~clk;

   soft_mute_ramp u_soft_mute_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .mute      (mute),
      .smp_valid (smp_valid),
      .smp_left  (smp_left),
      .smp_right (smp_right),
      .out_valid (out_valid),
      .out_left  (out_left),
      .out_right (out_right),
      .muted     (muted)
   );

   // {left in, right in, left expected, right expected} at full level
   localparam logic [63:0] UNITY_VEC [0:7] = '{
      64'h7FFF_8000_7FFF_8000,
      64'h8000_7FFF_8000_7FFF,
      64'h0000_0001_0000_0001,
      64'hFFFF_0000_FFFF_0000,
      64'h1234_EDCC_1234_EDCC,
      64'h5A5A_A5A5_5A5A_A5A5,
      64'h0100_FF00_0100_FF00,
      64'hC000_3FFF_C000_3FFF
   };

   function automatic logic signed [15:0] exp_scale(input logic signed [15:0] x, input int k);
      longint p;
      if (k == 0) return x;
      if (k == 128) return 16'sd0;
      p = longint'(x) * longint'((128 - k) * 512) + 64'sd32768;
      return 16'(p >>> 16);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_step();
      int tgt;
      tgt = mute ? 128 : 0;
      if (m_idx != tgt) begin
         if (m_cnt == 7) begin
            m_cnt = 0;
            m_idx = mute ? m_idx + 1 : m_idx - 1;
         end else begin
            m_cnt++;
         end
      end
   endtask

   // One strobe, then one idle cycle; checks R2, R3/R4, R8, R9
   task automatic strobe(input logic signed [15:0] l, input logic signed [15:0] r);
      logic signed [15:0] el;
      logic signed [15:0] er;
      @(negedge clk);
      check(out_valid == 1'b0, "R2 idle valid", out_valid, 0);
      smp_valid = 1'b1;
      smp_left  = l;
      smp_right = r;
      el = exp_scale(l, m_idx);
      er = exp_scale(r, m_idx);
      @(negedge clk);
      smp_valid = 1'b0;
      check(out_valid == 1'b1, "R2 valid", out_valid, 1);
      check(out_left == el, "R4 left", out_left, el);
      check(out_right == er, "R9 right", out_right, er);
      model_step();
      check(muted == (m_idx == 128), "R8 flag", muted, (m_idx == 128));
   endtask

   function automatic logic signed [15:0] pat(input int i, input int salt);
      return 16'((i * 7919 + salt * 40503) ^ 16'h5A5A);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      mute      = 1'b0;
      smp_valid = 1'b0;
      smp_left  = '0;
      smp_right = '0;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(out_valid == 1'b0, "R1 valid", out_valid, 0);
      check(out_left == 16'sd0, "R1 left", out_left, 0);
      check(out_right == 16'sd0, "R1 right", out_right, 0);
      check(muted == 1'b0, "R1 muted", muted, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && muted == 1'b0, "R1 after release", out_valid, 0);

      // R3, R9: table at full level
      for (int i = 0; i < 8; i++) begin
         strobe(UNITY_VEC[i][63:48], UNITY_VEC[i][47:32]);
         check(out_left == $signed(UNITY_VEC[i][31:16]), "R3 table left", out_left, $signed(UNITY_VEC[i][31:16]));
         check(out_right == $signed(UNITY_VEC[i][15:0]), "R3 table right", out_right, $signed(UNITY_VEC[i][15:0]));
      end

      // R2: outputs hold across idle cycles
      repeat (5) @(negedge clk);
      check(out_left == $signed(UNITY_VEC[7][31:16]) && out_valid == 1'b0, "R2 hold", out_left, $signed(UNITY_VEC[7][31:16]));

      // R10: mute pulses with no strobe leave the step alone
      mute = 1'b1;
      repeat (20) @(negedge clk);
      check(muted == 1'b0, "R10 no strobe", muted, 0);
      mute = 1'b0;
      strobe(16'sh7FFF, -16'sd1234);
      check(out_left == 16'sh7FFF, "R10 still unity", out_left, 16'sh7FFF);

      // R5: full fade down, 1023 strobes not yet silent
      mute = 1'b1;
      for (int i = 0; i < 1023; i++) strobe(pat(i, 1), pat(i, 2));
      check(muted == 1'b0, "R5 before last step", muted, 0);
      strobe(16'sh7FFF, 16'sh8000);
      check(muted == 1'b1, "R5 silent at 1024", muted, 1);

      // R8: full-scale input gives exact zero while silent
      strobe(16'sh8000, 16'sh7FFF);
      check(out_left == 16'sd0 && out_right == 16'sd0, "R8 zero", out_left, 0);

      // R6: fade back up
      mute = 1'b0;
      for (int i = 0; i < 1023; i++) strobe(pat(i, 3), pat(i, 4));
      check(muted == 1'b0, "R6 left silence", muted, 0);
      strobe(16'sd100, -16'sd100);
      strobe(16'sh8000, 16'sh7FFF);
      check(out_left == 16'sh8000 && out_right == 16'sh7FFF, "R6 full level", out_left, 16'sh8000);

      // R7: reverse after 100 strobes (step 12, dwell 4)
      mute = 1'b1;
      for (int i = 0; i < 100; i++) strobe(pat(i, 5), pat(i, 6));
      mute = 1'b0;
      for (int i = 0; i < 4; i++) strobe(pat(i, 7), pat(i, 8));
      strobe(16'sh7FFF, -16'sh7FFF);
      check(out_left == 16'sd29951, "R7 step kept after reversal", out_left, 29951);
      for (int i = 0; i < 100; i++) strobe(pat(i, 9), pat(i, 10));
      strobe(16'sh1357, 16'sh2468);
      check(out_left == 16'sh1357, "R7 back to full", out_left, 16'sh1357);

      // R11: reset in the middle of a fade
      mute = 1'b1;
      for (int i = 0; i < 300; i++) strobe(pat(i, 11), pat(i, 12));
      @(negedge clk);
      rst_n = 1'b0;
      mute  = 1'b0;
      m_idx = 0;
      m_cnt = 0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_left == 16'sd0 && muted == 1'b0, "R11 reset state", out_left, 0);
      rst_n = 1'b1;
      strobe(-16'sd32000, 16'sd31000);
      check(out_left == -16'sd32000 && out_right == 16'sd31000, "R11 full level", out_left, -32000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule